// File: doc/BRIEF.md
# Returned-Clock Multilane ADC Frame Capture

This block reads one conversion frame from a dual-channel converter that sends a clock back with its data. The block produces a serial clock and an active-low select toward the converter. The returned clock is one of two things. In echo mode it is a delayed copy of the serial clock that the block itself drives. In self-clocked mode the converter generates the clock on its own. Data comes in on two, four or eight serial lanes, which is one, two or four lanes per channel. In echo mode the bits can be sampled on both edges of the returned clock. In every other mode they are sampled on the rising edge only.

A frame holds 64 bits, 32 for each channel. The bits are packed into 16-bit words in the returned-clock domain. The words cross into the system clock domain through a four-entry gray-pointer FIFO. They then leave as a stream of eight bytes, each marked by a one-cycle valid strobe. A 2-bit mode code chooses the byte source. It can be this capture path, or a separate byte stream from a host-clocked SPI readout engine. A frame starts on a rising edge of the conversion-start input. It ends once eight bytes have left the block and the serial clock burst is complete.

Top module: `retclk_frame_capture`

## Requirements
- R1: After reset, cs_n is 1, sclk is 1 and out_valid is 0.
- R2: A rising edge on cnv, seen while no frame is open, drives cs_n low on the next clock edge. A rising edge that arrives while a frame is open starts nothing.
- R3: The block drives a burst of sclk pulses when the mode code is 2'b00 or 2'b01. sclk idles high. The pulse count is 32/L for single-edge sampling and 16/L for dual-edge sampling, where L is the number of lanes per channel.
- R4: The lane code sets L as follows: 2'b00 gives 1, 2'b01 gives 2, and 2'b10 or 2'b11 gives 4. Only sdi[2L-1:0] is read. Higher sdi bits have no effect on the output.
- R5: Each sampling event adds 2L bits to the frame stream, with sdi[2L-1] first. The frame leaves as eight bytes, most significant bit first. With dual-edge sampling, the falling-edge sample comes before the rising-edge sample that follows it.
- R6: Dual-edge sampling applies only when the mode code is 2'b01 and sdr_ddr_n is 0. In every other case, sampling happens on the rising edge of rtn_clk only.
- R7: With mode code 2'b00, the first eight spi_valid bytes of an open frame go to the output, one cycle later. spi_valid is ignored outside a frame and in the capture modes.
- R8: cs_n stays low until the eighth byte has been issued and the sclk burst has ended. cs_n rises on the clock edge after the eighth out_valid.
- R9: With mode code 2'b10 or 2'b11, rtn_clk is supplied by the converter and sclk stays high for the whole frame.
- R10: clk_mode, lane_sel and sdr_ddr_n are sampled when a frame starts. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv | input | 1 | Conversion start; a rising edge opens a frame |
| clk_mode | input | 2 | 00 host SPI bytes, 01 echo clock, 10/11 converter clock |
| lane_sel | input | 2 | Lanes per channel: 00=1, 01=2, 10/11=4 |
| sdr_ddr_n | input | 1 | 0 selects dual-edge sampling (honoured in echo mode only) |
| spi_data | input | 8 | Byte from the host-clocked SPI readout path |
| spi_valid | input | 1 | Strobe for spi_data |
| rtn_clk | input | 1 | Clock returned by the converter |
| sdi | input | 8 | Serial data lanes |
| sclk | output | 1 | Serial clock to the converter, idle high |
| cs_n | output | 1 | Active-low select, low for the whole frame |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | One-cycle strobe for out_data |

## Verification
The assertions rely on three conditions at the inputs:
- cnv, spi_valid and the configuration inputs are synchronous to clk.
- rtn_clk toggles only while cs_n is low.
- Each frame's 64 bits fit in the FIFO, so the write side never needs a full flag.

The stimulus meets these conditions in two ways. In echo mode, rtn_clk is simply the block's own sclk delayed by 2 ns. In self-clocked mode, it is a fixed burst of pulses that starts 30 ns after cs_n falls. The converter model changes its lanes 1 ns after each sampling edge. This leaves almost the whole half-period as setup margin. During a frame the bench deliberately toggles cnv and scrambles the configuration inputs, so that frame-start sampling is exercised against live inputs.

// File: rtl/retclk_frame_capture.sv
module retclk_frame_capture #(
  parameter int SCLK_DIV = 4,
  parameter int AW = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnv,
  input  logic [1:0] clk_mode,
  input  logic [1:0] lane_sel,
  input  logic       sdr_ddr_n,
  input  logic [7:0] spi_data,
  input  logic       spi_valid,
  input  logic       rtn_clk,
  input  logic [7:0] sdi,
  output logic       sclk,
  output logic       cs_n,
  output logic [7:0] out_data,
  output logic       out_valid
);
  localparam int FRAME_BYTES = 8;
  localparam int WORD_W = 16;
  localparam int DEPTH = 1 << AW;
  localparam int DCW = $clog2(SCLK_DIV);

  logic cnv_q, active, ddr_r, half;
  logic [1:0] mode_r, lanes_r;
  logic [DCW-1:0] div_cnt;
  logic [6:0] tog_left;
  logic [3:0] nbytes;
  logic [AW:0] rptr, wg_s1, wg_s2, wptr, wgray;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] acc, nxt;
  logic [4:0] bcnt, bpp;
  logic [7:0] fall_q;

  wire start    = cnv & ~cnv_q & ~active;
  wire cap_mode = mode_r != 2'b00;
  wire ddr_in   = (clk_mode == 2'b01) & ~sdr_ddr_n;
  wire [1:0] lc = (lane_sel == 2'b11) ? 2'b10 : lane_sel;
  wire [6:0] tog_in = clk_mode[1] ? 7'd0 : (ddr_in ? (7'd32 >> lc) : (7'd64 >> lc));
  wire [AW:0] rgray = rptr ^ (rptr >> 1);
  wire fifo_empty = wg_s2 == rgray;
  wire [WORD_W-1:0] rword = mem[rptr[AW-1:0]];
  wire done = active && nbytes == 4'(FRAME_BYTES) && tog_left == 7'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_q <= 1'b0; active <= 1'b0; cs_n <= 1'b1; sclk <= 1'b1;
      mode_r <= 2'b00; lanes_r <= 2'b00; ddr_r <= 1'b0;
      div_cnt <= '0; tog_left <= '0; nbytes <= '0; half <= 1'b0;
      rptr <= '0; out_valid <= 1'b0; out_data <= '0;
    end else begin
      cnv_q <= cnv;
      out_valid <= 1'b0;
      if (start) begin
        active <= 1'b1; cs_n <= 1'b0;
        mode_r <= clk_mode; lanes_r <= lc; ddr_r <= ddr_in;
        tog_left <= tog_in; div_cnt <= '0; nbytes <= '0; half <= 1'b0;
      end else if (active) begin
        if (done) begin
          active <= 1'b0;
          cs_n <= 1'b1;
        end
        if (tog_left != 7'd0) begin
          if (div_cnt == DCW'(SCLK_DIV - 1)) begin
            div_cnt <= '0;
            sclk <= ~sclk;
            tog_left <= tog_left - 7'd1;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        if (nbytes != 4'(FRAME_BYTES)) begin
          if (!cap_mode) begin
            if (spi_valid) begin
              out_valid <= 1'b1; out_data <= spi_data; nbytes <= nbytes + 4'd1;
            end
          end else if (half) begin
            out_valid <= 1'b1; out_data <= rword[7:0];
            rptr <= rptr + 1'b1; half <= 1'b0; nbytes <= nbytes + 4'd1;
          end else if (!fifo_empty) begin
            out_valid <= 1'b1; out_data <= rword[15:8];
            half <= 1'b1; nbytes <= nbytes + 4'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wg_s1 <= '0; wg_s2 <= '0;
    end else begin
      wg_s1 <= wgray; wg_s2 <= wg_s1;
    end
  end

  // returned-clock domain
  wire clr = cs_n | ~rst_n;
  wire push = cap_mode && !cs_n && (bcnt + bpp == 5'd16);
  wire [AW:0] wnext = wptr + 1'b1;

  always_comb begin
    case ({ddr_r, lanes_r})
      3'b000: begin nxt = {acc[13:0], sdi[1:0]};              bpp = 5'd2;  end
      3'b001: begin nxt = {acc[11:0], sdi[3:0]};              bpp = 5'd4;  end
      3'b100: begin nxt = {acc[11:0], fall_q[1:0], sdi[1:0]}; bpp = 5'd4;  end
      3'b101: begin nxt = {acc[7:0], fall_q[3:0], sdi[3:0]};  bpp = 5'd8;  end
      3'b110: begin nxt = {fall_q, sdi};                      bpp = 5'd16; end
      default: begin nxt = {acc[7:0], sdi};                   bpp = 5'd8;  end
    endcase
  end

  always_ff @(negedge rtn_clk or posedge clr) begin
    if (clr) fall_q <= '0;
    else     fall_q <= sdi;
  end

  always_ff @(posedge rtn_clk or posedge clr) begin
    if (clr) begin
      acc <= '0; bcnt <= '0;
    end else if (cap_mode) begin
      acc <= nxt;
      bcnt <= push ? 5'd0 : bcnt + bpp;
    end
  end

  always_ff @(posedge rtn_clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; wgray <= '0;
    end else if (push) begin
      wptr <= wnext; wgray <= wnext ^ (wnext >> 1);
    end
  end

  always_ff @(posedge rtn_clk) begin
    if (push) mem[wptr[AW-1:0]] <= nxt;
  end

  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> sclk);
  // R8
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(nbytes) == 4'(FRAME_BYTES));
  // R8
  byte_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) active |-> nbytes <= 4'(FRAME_BYTES));
  // R7
  valid_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !cs_n);
  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> ($stable(mode_r) && $stable(lanes_r) && $stable(ddr_r)));
  // R6
  ddr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n) ddr_r |-> mode_r == 2'b01);
  // R9
  master_no_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n && mode_r[1]) |-> sclk);
endmodule

// File: tb/retclk_frame_capture_test.sv
`timescale 1ns/1ps
module retclk_frame_capture_test;
  logic clk = 1'b0, rst_n = 1'b0, cnv = 1'b0;
  logic [1:0] clk_mode = 2'b01, lane_sel = 2'b00;
  logic sdr_ddr_n = 1'b1, spi_valid = 1'b0;
  logic [7:0] spi_data = 8'h00, sdi = 8'h00, out_data;
  logic sclk, cs_n, out_valid, rtn_clk, rtn_e;
  logic rtn_m = 1'b1;
  logic use_master = 1'b0, cur_ddr = 1'b0;
  int cur_l = 1, k = 0;
  logic [63:0] cur_frame = '0;
  int checks = 0, fails = 0;
  int nb = 0, sclk_cnt = 0, cs_falls = 0, cyc = 0, t8 = 0, tcs = 0;
  logic cs_prev = 1'b1;
  logic [7:0] got [16];

  always #4 clk = ~clk;

  retclk_frame_capture uut (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .clk_mode(clk_mode), .lane_sel(lane_sel),
    .sdr_ddr_n(sdr_ddr_n), .spi_data(spi_data), .spi_valid(spi_valid),
    .rtn_clk(rtn_clk), .sdi(sdi), .sclk(sclk), .cs_n(cs_n),
    .out_data(out_data), .out_valid(out_valid));

  assign #2 rtn_e = sclk;
  assign rtn_clk = use_master ? rtn_m : rtn_e;

  task automatic drive_sdi();
    logic [63:0] seg;
    logic [7:0] mask;
    int w;
    w = 2 * cur_l;
    seg = (k * w < 64) ? (cur_frame >> (64 - (k + 1) * w)) : 64'd0;
    mask = 8'hFF >> (8 - w);
    sdi = (seg[7:0] & mask) | (8'(k * 53 + 17) & ~mask);
  endtask

  always begin
    @(negedge cs_n);
    k = 0;
    drive_sdi();
    while (!cs_n) begin
      @(rtn_clk or posedge cs_n);
      if (cs_n) break;
      if (rtn_clk || cur_ddr) begin
        #1;
        k = k + 1;
        drive_sdi();
      end
    end
  end

  always begin
    @(negedge cs_n);
    if (use_master) begin
      #30;
      repeat (32 / cur_l) begin
        rtn_m = 1'b0; #20;
        rtn_m = 1'b1; #20;
      end
    end
  end

  always @(posedge sclk) if (!cs_n) sclk_cnt++;
  always @(negedge cs_n) cs_falls++;

  always @(negedge clk) begin
    cyc++;
    if (out_valid) begin
      if (nb < 16) got[nb] = out_data;
      nb++;
      if (nb == 8) t8 = cyc;
    end
    if (cs_n && !cs_prev) tcs = cyc;
    cs_prev = cs_n;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_frame_end();
    int t;
    t = 0;
    while (!cs_n && t < 4000) begin
      @(negedge clk);
      t++;
    end
    repeat (10) @(negedge clk);
  endtask

  // {clk_mode, lane_sel, sdr_ddr_n, frame}
  localparam logic [68:0] VEC [10] = '{
    {2'b01, 2'b00, 1'b1, 64'h0123_4567_89AB_CDEF},
    {2'b01, 2'b01, 1'b1, 64'hFEDC_BA98_7654_3210},
    {2'b01, 2'b10, 1'b1, 64'hA5A5_5A5A_C3C3_3C3C},
    {2'b01, 2'b00, 1'b0, 64'h1357_9BDF_2468_ACE0},
    {2'b01, 2'b01, 1'b0, 64'hDEAD_BEEF_0BAD_F00D},
    {2'b01, 2'b10, 1'b0, 64'h8000_0000_0000_0001},
    {2'b01, 2'b11, 1'b0, 64'h0F1E_2D3C_4B5A_6978},
    {2'b10, 2'b01, 1'b1, 64'h7766_5544_3322_1100},
    {2'b10, 2'b10, 1'b0, 64'hCAFE_F00D_1234_5678},
    {2'b11, 2'b00, 1'b1, 64'h3141_5926_5358_9793}
  };

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", cs_n, 1'b1);
    chk("R1 sclk", sclk, 1'b1);
    chk("R1 out_valid", out_valid, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    spi_valid = 1'b1;
    spi_data = 8'h00;
    for (int v = 0; v < 10; v++) begin
      logic [1:0] m, l;
      logic s;
      int exp_p;
      m = VEC[v][68:67]; l = VEC[v][66:65]; s = VEC[v][64];
      cur_frame = VEC[v][63:0];
      cur_l = (l == 2'b00) ? 1 : (l == 2'b01) ? 2 : 4;
      cur_ddr = (m == 2'b01) && !s;
      use_master = m[1];
      exp_p = m[1] ? 0 : ((cur_ddr ? 16 : 32) / cur_l);
      clk_mode = m; lane_sel = l; sdr_ddr_n = s;
      @(negedge clk);
      nb = 0; sclk_cnt = 0; cs_falls = 0; t8 = -10; tcs = -20;
      cnv = 1'b1;
      @(negedge clk);
      cnv = 1'b0;
      repeat (20) @(negedge clk);
      // R2 / R10: re-trigger and scramble configuration mid-frame
      cnv = 1'b1; clk_mode = ~m; lane_sel = ~l; sdr_ddr_n = ~s;
      @(negedge clk);
      cnv = 1'b0;
      wait_frame_end();
      for (int i = 0; i < 8; i++)
        chk("R5 R4 R6 R9 R10 byte", {56'd0, got[i]}, {56'd0, cur_frame[63 - 8 * i -: 8]});
      chk("R5 R7 byte count", nb, 8);
      chk("R3 R9 sclk pulses", sclk_cnt, exp_p);
      chk("R2 single frame", cs_falls, 1);
      chk("R8 cs_n release", tcs, t8 + 1);
    end

    // R7: spi_valid ignored outside a frame
    clk_mode = 2'b00; lane_sel = 2'b10; sdr_ddr_n = 1'b1;
    use_master = 1'b0; cur_ddr = 1'b0; cur_l = 4;
    nb = 0;
    repeat (5) begin
      @(negedge clk); spi_valid = 1'b1; spi_data = 8'h5C;
      @(negedge clk); spi_valid = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk("R7 idle spi ignored", nb, 0);

    // R7 / R3: host SPI byte path, four lanes -> 8 sclk pulses
    nb = 0; sclk_cnt = 0; cs_falls = 0;
    cnv = 1'b1;
    @(negedge clk);
    cnv = 1'b0;
    repeat (100) @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      spi_valid = 1'b1; spi_data = 8'(8'h21 * (i + 1));
      @(negedge clk);
      spi_valid = 1'b0;
      repeat (2) @(negedge clk);
    end
    wait_frame_end();
    for (int i = 0; i < 8; i++)
      chk("R7 spi byte", {56'd0, got[i]}, {56'd0, 8'(8'h21 * (i + 1))});
    chk("R7 spi byte count", nb, 8);
    chk("R3 spi mode sclk pulses", sclk_cnt, 8);
    chk("R8 spi cs_n release", tcs, t8 + 1);
    chk("R2 spi single frame", cs_falls, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule